// File: doc/BRIEF.md
# I2C Slave Control Register Bank

This block is the register file that sits behind an I2C slave transport engine. The engine hands it a one-byte register selector at the start of each register access. It then passes the written bytes through one at a time, or pulls read bytes one at a time. The bank decodes the selector and assembles or splits multi-byte values with the most significant byte first. It holds the link configuration: payload length limit, slave address, SCL ceiling, guard time, transmission timeout and bus-speed mode. It also presents a read-only status word built from the busy, response-ready and response-length inputs.

Changes to the slave address and to the speed mode are staged. They take effect on the next bus access, which the engine marks with a start strobe. Any byte written to the soft-reset register raises a one-cycle warm-reset pulse. That pulse reloads the configuration. The address and mode come back from persistent copies, which a write with bit 15 set updates. The cold reset input restores the factory values, including those persistent copies. Register selector 0x80 belongs to the payload buffer. The bank only flags it while it is selected.

Top module: `i2c_regbank`

## Requirements
- R1: After cold reset (rst_n low at a clock edge) slave_addr_o is 0x30, bus_mode_o is 3, warm_rst_o is 0, the length register reads 0x0400, the SCL register reads 400, the guard register reads 200 and the timeout register reads 20.
- R2: A selector pulse chooses a register and restarts its byte position. Multi-byte values move most significant byte first. A write commits only when the register's full byte count has arrived, so a partial write is discarded. A read past the last byte returns 0xFF. Byte counts: length 2, status 4, address 2 (write only), SCL 4, guard 4, timeout 4, soft reset 1 (write only), mode 2.
- R3: Every read byte of an undefined selector, of the write-only selectors 0x83 and 0x88, and of 0x80 is 0xFF. Writes to undefined selectors change no register.
- R4: A value written to the length register (0x81) is stored as 0x0010 when below 0x0010, as 0x0400 when above 0x0400, and unchanged otherwise.
- R5: The status register (0x82) reads {busy_i, resp_rdy_i, 2'b00, 4'b1011, 8'h00, resp_len_i[15:0]}. Bits 27:24 report soft-reset support, continue-read, repeated start and clock stretching.
- R6: A write to the address register (0x83) takes bits 6:0 as the new address. slave_addr_o adopts it at the first bus_start_i after the write completes. A write that completes in the same cycle as bus_start_i waits for the next one.
- R7: The mode register (0x89) accepts codes 1 (standard), 2 (fast), 3 (standard and fast) and 4 (fast-plus) in bits 2:0. A write with any other code is ignored. An accepted code reaches bus_mode_o at the next bus_start_i. Reads return the code in force with bit 15 as 0.
- R8: The SCL register (0x84) is held within 50 and a ceiling set by the mode in force: 100 for code 1, 400 for codes 2 and 3, and 1000 for code 4. Written values are clamped to the ceiling of the mode in force after that clock edge. A mode change re-clamps the stored value.
- R9: Writing any byte to 0x88 pulses warm_rst_o high for exactly the next cycle. The same write returns length, guard and timeout to their cold-reset values and the SCL register to 400 fitted to the restored mode. It also drops any staged address or mode and ends the current register access.
- R10: An address or mode write with bit 15 set also stores that value as the persistent copy. A warm reset restores slave_addr_o and bus_mode_o from the persistent copies. A cold reset returns those copies to 0x30 and 3.
- R11: The guard (0x85) and timeout (0x86) registers store and return any 32-bit value.
- R12: data_sel_o is high exactly while selector 0x80 is the current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| bus_start_i | input | 1 | Strobe marking the start of a master access to this slave |
| sel_vld_i | input | 1 | Register selector strobe |
| sel_addr_i | input | 8 | Register selector |
| wr_vld_i | input | 1 | Write byte strobe |
| wr_byte_i | input | 8 | Write byte |
| rd_ack_i | input | 1 | Read byte consumed, advance to next byte |
| busy_i | input | 1 | Slave busy, shown in status |
| resp_rdy_i | input | 1 | Response ready, shown in status |
| resp_len_i | input | 16 | Response length, shown in status |
| rd_byte_o | output | 8 | Current read byte |
| data_sel_o | output | 1 | Payload register is selected |
| slave_addr_o | output | 7 | Slave address in force |
| bus_mode_o | output | 3 | Bus-speed mode in force |
| warm_rst_o | output | 1 | One-cycle warm-reset pulse |

## Verification
Two events can meet in the same cycle: the final byte of an address write committing, and the bus-start strobe applying the staged address. The bench stages one address and then writes a second one whose last byte is driven together with bus_start_i. It expects the first address to appear on slave_addr_o after that edge and the second only after a further bus start. The bench also checks SCL clamping under each mode and the re-clamp when a new mode is applied.

// File: rtl/i2crb_pkg.sv
// Shared constants and helpers for the I2C slave register bank.
// Assumes the register selectors are fixed by the transport's register map.
package i2crb_pkg;
    localparam int IDX_W = 3;
    localparam logic [7:0] RA_DATA  = 8'h80;
    localparam logic [7:0] RA_LEN   = 8'h81;
    localparam logic [7:0] RA_STATE = 8'h82;
    localparam logic [7:0] RA_ADDR  = 8'h83;
    localparam logic [7:0] RA_SCL   = 8'h84;
    localparam logic [7:0] RA_GUARD = 8'h85;
    localparam logic [7:0] RA_TMO   = 8'h86;
    localparam logic [7:0] RA_WARM  = 8'h88;
    localparam logic [7:0] RA_MODE  = 8'h89;
    localparam logic [31:0] SCL_MIN = 32'd50;

    // Readable byte count of a selector (0 = not readable here)
    function automatic logic [IDX_W-1:0] rd_bytes(input logic [7:0] a);
        case (a)
            RA_LEN, RA_MODE:                     return 3'd2;
            RA_STATE, RA_SCL, RA_GUARD, RA_TMO:  return 3'd4;
            default:                             return 3'd0;
        endcase
    endfunction

    // Writable byte count of a selector (0 = not writable here)
    function automatic logic [IDX_W-1:0] wr_bytes(input logic [7:0] a);
        case (a)
            RA_LEN, RA_ADDR, RA_MODE:    return 3'd2;
            RA_SCL, RA_GUARD, RA_TMO:    return 3'd4;
            RA_WARM:                     return 3'd1;
            default:                     return 3'd0;
        endcase
    endfunction

    function automatic logic mode_ok(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    function automatic logic [31:0] scl_top(input logic [2:0] m);
        case (m)
            3'd1:    return 32'd100;
            3'd4:    return 32'd1000;
            default: return 32'd400;
        endcase
    endfunction

    function automatic logic [31:0] scl_fit(input logic [31:0] v, input logic [2:0] m);
        if (v < SCL_MIN)    return SCL_MIN;
        if (v > scl_top(m)) return scl_top(m);
        return v;
    endfunction
endpackage

// File: rtl/i2crb_port.sv
// Byte-stream front end: tracks the selected register and byte position,
// assembles writes MSB first and slices the read value into bytes.
// Assumes the engine never raises sel_vld together with wr_vld or rd_ack.
module i2crb_port
    import i2crb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_vld,
    input  logic [7:0]       sel_addr,
    input  logic             wr_vld,
    input  logic [7:0]       wr_byte,
    input  logic             rd_ack,
    input  logic             flush,
    input  logic [31:0]      rd_val,
    output logic [7:0]       cur_addr,
    output logic             cur_ok,
    output logic             commit,
    output logic [31:0]      commit_val,
    output logic [7:0]       rd_byte
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx_q;
    logic [23:0]      sh_q;
    logic [IDX_W-1:0] wr_w, rd_w, rd_left;
    logic [5:0]       shamt;
    logic [31:0]      shifted;

    // Selection, byte position and write assembly
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cur_addr <= '0;
            cur_ok   <= 1'b0;
            idx_q    <= '0;
            sh_q     <= '0;
        end else if (sel_vld) begin
            cur_addr <= sel_addr;
            cur_ok   <= 1'b1;
            idx_q    <= '0;
            sh_q     <= '0;
        end else if (cur_ok && (wr_vld || rd_ack)) begin
            if (wr_vld) sh_q <= {sh_q[15:0], wr_byte};
            if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
        end
    end

    // Commit strobe when the last byte of a writable register arrives
    always_comb begin
        wr_w       = wr_bytes(cur_addr);
        commit     = cur_ok && !sel_vld && wr_vld && (wr_w != '0) && (idx_q == wr_w - 1'b1);
        commit_val = {sh_q, wr_byte};
    end

    // Read byte slicing, 0xFF outside the readable range
    always_comb begin
        rd_w    = rd_bytes(cur_addr);
        rd_left = rd_w - 1'b1 - idx_q;
        shamt   = {rd_left, 3'b000};
        shifted = rd_val >> shamt;
        rd_byte = (cur_ok && idx_q < rd_w) ? shifted[7:0] : 8'hFF;
    end

    // R2
    sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && !flush) |=> (cur_ok && idx_q == '0));
endmodule

// File: rtl/i2crb_cfg.sv
// Configuration storage: staged address/mode, persistent copies, clamped
// length and SCL, guard and timeout, and the warm-reset pulse.
// Assumes DEF_MODE is a valid mode code and MAX_LEN is at least 0x10.
module i2crb_cfg
    import i2crb_pkg::*;
#(
    parameter logic [15:0] MAX_LEN   = 16'h0400,
    parameter logic [6:0]  DEF_ADDR  = 7'h30,
    parameter logic [2:0]  DEF_MODE  = 3'd3,
    parameter logic [31:0] DEF_SCL   = 32'd400,
    parameter logic [31:0] GUARD_DEF = 32'd200,
    parameter logic [31:0] TMO_DEF   = 32'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_start,
    input  logic        commit,
    input  logic [7:0]  commit_reg,
    input  logic [31:0] commit_val,
    output logic        warm_hit,
    output logic [6:0]  addr_o,
    output logic [2:0]  mode_o,
    output logic [31:0] scl_o,
    output logic [15:0] len_o,
    output logic [31:0] guard_o,
    output logic [31:0] tmo_o,
    output logic        warm_rst_o
);
    localparam logic [15:0] LEN_MIN = 16'h0010;

    logic [6:0] a_new, a_sh;
    logic       a_pend;
    logic [2:0] m_new, m_sh, mode_next;
    logic       m_pend;
    logic       c_len, c_addr, c_scl, c_guard, c_tmo, c_mode;

    // Decode of the committed register
    always_comb begin
        warm_hit  = commit && commit_reg == RA_WARM;
        c_len     = commit && commit_reg == RA_LEN;
        c_addr    = commit && commit_reg == RA_ADDR;
        c_scl     = commit && commit_reg == RA_SCL;
        c_guard   = commit && commit_reg == RA_GUARD;
        c_tmo     = commit && commit_reg == RA_TMO;
        c_mode    = commit && commit_reg == RA_MODE && mode_ok(commit_val[2:0]);
        mode_next = (bus_start && m_pend) ? m_new : mode_o;
    end

    // Slave address: staging, application on bus start, persistence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= DEF_ADDR; a_sh <= DEF_ADDR; a_new <= '0; a_pend <= 1'b0;
        end else if (warm_hit) begin
            addr_o <= a_sh; a_pend <= 1'b0;
        end else begin
            if (bus_start && a_pend) addr_o <= a_new;
            if (c_addr) begin
                a_new  <= commit_val[6:0];
                a_pend <= 1'b1;
                if (commit_val[15]) a_sh <= commit_val[6:0];
            end else if (bus_start) begin
                a_pend <= 1'b0;
            end
        end
    end

    // Bus-speed mode: staging, application on bus start, persistence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= DEF_MODE; m_sh <= DEF_MODE; m_new <= DEF_MODE; m_pend <= 1'b0;
        end else if (warm_hit) begin
            mode_o <= m_sh; m_pend <= 1'b0;
        end else begin
            mode_o <= mode_next;
            if (c_mode) begin
                m_new  <= commit_val[2:0];
                m_pend <= 1'b1;
                if (commit_val[15]) m_sh <= commit_val[2:0];
            end else if (bus_start) begin
                m_pend <= 1'b0;
            end
        end
    end

    // SCL ceiling kept inside the limits of the mode in force
    always_ff @(posedge clk) begin
        if (!rst_n)                   scl_o <= DEF_SCL;
        else if (warm_hit)            scl_o <= scl_fit(DEF_SCL, m_sh);
        else if (c_scl)               scl_o <= scl_fit(commit_val, mode_next);
        else if (bus_start && m_pend) scl_o <= scl_fit(scl_o, mode_next);
    end

    // Length, guard and timeout registers
    always_ff @(posedge clk) begin
        if (!rst_n || warm_hit) begin
            len_o <= MAX_LEN; guard_o <= GUARD_DEF; tmo_o <= TMO_DEF;
        end else begin
            if (c_len) begin
                if (commit_val[15:0] < LEN_MIN)      len_o <= LEN_MIN;
                else if (commit_val[15:0] > MAX_LEN) len_o <= MAX_LEN;
                else                                 len_o <= commit_val[15:0];
            end
            if (c_guard) guard_o <= commit_val;
            if (c_tmo)   tmo_o   <= commit_val;
        end
    end

    // Warm-reset pulse, one cycle after the triggering byte
    always_ff @(posedge clk) begin
        if (!rst_n) warm_rst_o <= 1'b0;
        else        warm_rst_o <= warm_hit;
    end

    // R4
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_o >= LEN_MIN) && (len_o <= MAX_LEN));
    // R8
    scl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o >= SCL_MIN) && (scl_o <= scl_top(mode_o)));
    // R7
    mode_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(mode_o));
    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_o) |-> $past(bus_start || warm_hit));
    // R9
    warm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |=> !warm_rst_o);
endmodule

// File: rtl/i2c_regbank.sv
// Top of the I2C slave control register bank: joins the byte-stream front
// end to the configuration store and builds the read value per selector.
// Assumes the I2C engine and payload buffer live outside this block.
module i2c_regbank
    import i2crb_pkg::*;
#(
    parameter logic [15:0] MAX_LEN   = 16'h0400,
    parameter logic [6:0]  DEF_ADDR  = 7'h30,
    parameter logic [3:0]  CAPS      = 4'b1011,
    parameter logic [31:0] GUARD_DEF = 32'd200,
    parameter logic [31:0] TMO_DEF   = 32'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_start_i,
    input  logic        sel_vld_i,
    input  logic [7:0]  sel_addr_i,
    input  logic        wr_vld_i,
    input  logic [7:0]  wr_byte_i,
    input  logic        rd_ack_i,
    input  logic        busy_i,
    input  logic        resp_rdy_i,
    input  logic [15:0] resp_len_i,
    output logic [7:0]  rd_byte_o,
    output logic        data_sel_o,
    output logic [6:0]  slave_addr_o,
    output logic [2:0]  bus_mode_o,
    output logic        warm_rst_o
);
    logic [7:0]  cur_addr;
    logic        cur_ok, commit, warm_hit;
    logic [31:0] commit_val, rd_val, scl, guard, tmo;
    logic [15:0] len;

    i2crb_port u_port (
        .clk(clk), .rst_n(rst_n),
        .sel_vld(sel_vld_i), .sel_addr(sel_addr_i),
        .wr_vld(wr_vld_i), .wr_byte(wr_byte_i), .rd_ack(rd_ack_i),
        .flush(warm_hit), .rd_val(rd_val),
        .cur_addr(cur_addr), .cur_ok(cur_ok),
        .commit(commit), .commit_val(commit_val), .rd_byte(rd_byte_o)
    );

    i2crb_cfg #(
        .MAX_LEN(MAX_LEN), .DEF_ADDR(DEF_ADDR),
        .GUARD_DEF(GUARD_DEF), .TMO_DEF(TMO_DEF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start_i),
        .commit(commit), .commit_reg(cur_addr), .commit_val(commit_val),
        .warm_hit(warm_hit), .addr_o(slave_addr_o), .mode_o(bus_mode_o),
        .scl_o(scl), .len_o(len), .guard_o(guard), .tmo_o(tmo),
        .warm_rst_o(warm_rst_o)
    );

    // Read value of the selected register
    always_comb begin
        case (cur_addr)
            RA_LEN:   rd_val = {16'h0000, len};
            RA_STATE: rd_val = {busy_i, resp_rdy_i, 2'b00, CAPS, 8'h00, resp_len_i};
            RA_SCL:   rd_val = scl;
            RA_GUARD: rd_val = guard;
            RA_TMO:   rd_val = tmo;
            RA_MODE:  rd_val = {29'd0, bus_mode_o};
            default:  rd_val = 32'hFFFF_FFFF;
        endcase
        data_sel_o = cur_ok && (cur_addr == RA_DATA);
    end

    // R12
    data_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_sel_o |-> (rd_byte_o == 8'hFF));
endmodule

// File: tb/i2c_regbank_test.sv
module i2c_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MAXL = 16'h0400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_start = 0, sel_vld = 0, wr_vld = 0, rd_ack = 0;
    logic busy = 0, rdy = 0;
    logic [7:0] sel_addr = 0, wr_byte = 0;
    logic [15:0] resp_len = 0;
    logic [7:0] rd_byte;
    logic data_sel, warm_rst;
    logic [6:0] saddr;
    logic [2:0] bmode;
    int errors = 0, checks = 0;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_start_i(bus_start),
        .sel_vld_i(sel_vld), .sel_addr_i(sel_addr),
        .wr_vld_i(wr_vld), .wr_byte_i(wr_byte), .rd_ack_i(rd_ack),
        .busy_i(busy), .resp_rdy_i(rdy), .resp_len_i(resp_len),
        .rd_byte_o(rd_byte), .data_sel_o(data_sel),
        .slave_addr_o(saddr), .bus_mode_o(bmode), .warm_rst_o(warm_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cold_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_sel(input logic [7:0] a);
        @(negedge clk); sel_vld = 1; sel_addr = a;
        @(negedge clk); sel_vld = 0;
    endtask

    task automatic do_wr(input logic [7:0] b);
        @(negedge clk); wr_vld = 1; wr_byte = b;
        @(negedge clk); wr_vld = 0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input int n, input logic [31:0] val);
        do_sel(a);
        for (int i = n - 1; i >= 0; i--) do_wr(val[8*i +: 8]);
    endtask

    task automatic rd_reg(input logic [7:0] a, input int n, output logic [31:0] val);
        do_sel(a);
        val = 0;
        for (int i = 0; i < n; i++) begin
            #1 val = {val[23:0], rd_byte};
            rd_ack = 1;
            @(negedge clk); rd_ack = 0;
        end
    endtask

    task automatic pulse_bus();
        @(negedge clk); bus_start = 1;
        @(negedge clk); bus_start = 0;
    endtask

    function automatic logic [31:0] ceil_of(input logic [2:0] m);
        return (m == 3'd1) ? 32'd100 : (m == 3'd4) ? 32'd1000 : 32'd400;
    endfunction

    function automatic logic [31:0] fit(input logic [31:0] x, input logic [2:0] m);
        return (x < 50) ? 32'd50 : (x > ceil_of(m)) ? ceil_of(m) : x;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] cur_mode;
        cold_reset();
        // R1 reset state
        #1;
        chk("R1 addr", {25'd0, saddr}, 32'h30);
        chk("R1 mode", {29'd0, bmode}, 32'd3);
        chk("R1 warm", {31'd0, warm_rst}, 32'd0);
        rd_reg(8'h81, 2, v); chk("R1 len", v, 32'h0400);
        rd_reg(8'h84, 4, v); chk("R1 scl", v, 32'd400);
        rd_reg(8'h85, 4, v); chk("R1 guard", v, 32'd200);
        rd_reg(8'h86, 4, v); chk("R1 tmo", v, 32'd20);

        // R3 sweep of every non-readable selector
        for (int a = 0; a < 256; a++) begin
            if (!(a inside {8'h81, 8'h82, 8'h84, 8'h85, 8'h86, 8'h89})) begin
                rd_reg(a[7:0], 4, v);
                chk($sformatf("R3 rd %02h", a), v, 32'hFFFF_FFFF);
            end
        end
        // R3 undefined writes leave registers unchanged
        wr_reg(8'h8A, 4, 32'h1234_5678);
        wr_reg(8'h87, 4, 32'h0000_0011);
        rd_reg(8'h81, 2, v); chk("R3 len kept", v, 32'h0400);
        rd_reg(8'h85, 4, v); chk("R3 guard kept", v, 32'd200);

        // R12 data select flag
        do_sel(8'h80); #1 chk("R12 data_sel on", {31'd0, data_sel}, 1);
        do_sel(8'h81); #1 chk("R12 data_sel off", {31'd0, data_sel}, 0);

        // R4 length clamp sweep
        for (int k = 0; k < 9; k++) begin
            logic [15:0] lv;
            logic [15:0] e;
            case (k)
                0: lv = 16'h0000; 1: lv = 16'h0001; 2: lv = 16'h000F;
                3: lv = 16'h0010; 4: lv = 16'h0011; 5: lv = MAXL - 1;
                6: lv = MAXL;     7: lv = MAXL + 1; default: lv = 16'hFFFF;
            endcase
            e = (lv < 16'h10) ? 16'h10 : (lv > MAXL) ? MAXL : lv;
            wr_reg(8'h81, 2, {16'h0, lv});
            rd_reg(8'h81, 2, v);
            chk($sformatf("R4 len %04h", lv), v, {16'h0, e});
        end

        // R2 partial write discarded, read past end is 0xFF, MSB first
        wr_reg(8'h81, 2, 32'h0123);
        do_sel(8'h81); do_wr(8'h00);
        do_sel(8'h82);
        rd_reg(8'h81, 3, v); chk("R2 partial+overrun", v, 32'h0001_23FF);

        // R5 status layout sweep
        for (int s = 0; s < 4; s++) begin
            busy = s[1]; rdy = s[0]; resp_len = 16'hA5C3 + 16'(s);
            rd_reg(8'h82, 4, v);
            chk("R5 status", v, {busy, rdy, 2'b00, 4'b1011, 8'h00, resp_len});
        end

        // R11 guard and timeout
        wr_reg(8'h85, 4, 32'hDEAD_BEEF); rd_reg(8'h85, 4, v); chk("R11 guard", v, 32'hDEAD_BEEF);
        wr_reg(8'h86, 4, 32'h0000_0001); rd_reg(8'h86, 4, v); chk("R11 tmo", v, 32'h0000_0001);

        // R7 mode code sweep, staged until bus start
        cur_mode = 3'd3;
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cc;
            cc = c[2:0];
            wr_reg(8'h89, 2, {29'd0, cc});
            rd_reg(8'h89, 2, v); chk("R7 staged", v, {29'd0, cur_mode});
            pulse_bus();
            if (cc >= 1 && cc <= 4) cur_mode = cc;
            #1 chk($sformatf("R7 mode code %0d", c), {29'd0, bmode}, {29'd0, cur_mode});
        end

        // R8 SCL clamp sweep under every valid mode
        for (int m = 1; m <= 4; m++) begin
            wr_reg(8'h89, 2, m); pulse_bus();
            for (int k = 0; k < 14; k++) begin
                logic [31:0] sv;
                case (k)
                    0: sv = 0;    1: sv = 49;   2: sv = 50;   3: sv = 51;
                    4: sv = 99;   5: sv = 100;  6: sv = 101;  7: sv = 399;
                    8: sv = 400;  9: sv = 401;  10: sv = 999; 11: sv = 1000;
                    12: sv = 1001; default: sv = 32'hFFFF_FFFF;
                endcase
                wr_reg(8'h84, 4, sv);
                rd_reg(8'h84, 4, v);
                chk($sformatf("R8 scl m%0d v%0d", m, sv), v, fit(sv, m[2:0]));
            end
        end
        // R8 re-clamp on mode change: mode 4 now, scl 1000 -> mode 1
        wr_reg(8'h84, 4, 32'd1000);
        wr_reg(8'h89, 2, 32'd1); pulse_bus();
        rd_reg(8'h84, 4, v); chk("R8 reclamp", v, 32'd100);

        // R6 staged address and same-cycle commit with bus start
        wr_reg(8'h83, 2, 32'h0055);
        #1 chk("R6 not yet", {25'd0, saddr}, 32'h30);
        pulse_bus(); #1 chk("R6 applied", {25'd0, saddr}, 32'h55);
        wr_reg(8'h83, 2, 32'h0011);
        do_sel(8'h83); do_wr(8'h00);
        @(negedge clk); wr_vld = 1; wr_byte = 8'h22; bus_start = 1;
        @(negedge clk); wr_vld = 0; bus_start = 0;
        #1 chk("R6 collide old", {25'd0, saddr}, 32'h11);
        pulse_bus(); #1 chk("R6 collide new", {25'd0, saddr}, 32'h22);

        // R10 persistence and R9 warm reset
        wr_reg(8'h83, 2, 32'h8042); pulse_bus();
        wr_reg(8'h89, 2, 32'h8004); pulse_bus();
        rd_reg(8'h89, 2, v); chk("R7 bit15 reads 0", v, 32'h0004);
        wr_reg(8'h83, 2, 32'h0066); pulse_bus();
        wr_reg(8'h89, 2, 32'h0002); pulse_bus();
        wr_reg(8'h81, 2, 32'h0020);
        wr_reg(8'h85, 4, 32'd7);
        wr_reg(8'h89, 2, 32'h0001);
        do_sel(8'h88);
        @(negedge clk); wr_vld = 1; wr_byte = 8'h5A;
        @(negedge clk); wr_vld = 0;
        #1 chk("R9 pulse high", {31'd0, warm_rst}, 1);
        @(negedge clk); #1 chk("R9 pulse low", {31'd0, warm_rst}, 0);
        chk("R10 addr restored", {25'd0, saddr}, 32'h42);
        chk("R10 mode restored", {29'd0, bmode}, 32'd4);
        pulse_bus(); #1 chk("R9 staged mode dropped", {29'd0, bmode}, 32'd4);
        rd_reg(8'h81, 2, v); chk("R9 len default", v, 32'h0400);
        rd_reg(8'h85, 4, v); chk("R9 guard default", v, 32'd200);
        rd_reg(8'h84, 4, v); chk("R9 scl default", v, 32'd400);

        // R10 cold reset restores factory persistent copies
        cold_reset();
        #1 chk("R10 cold addr", {25'd0, saddr}, 32'h30);
        chk("R10 cold mode", {29'd0, bmode}, 32'd3);
        wr_reg(8'h88, 1, 32'h0);
        @(negedge clk);
        #1 chk("R10 warm after cold addr", {25'd0, saddr}, 32'h30);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule